// File: doc/BRIEF.md
# Link Signal-Detect and Frequency Monitor

This block decides whether the selected serial receive path carries a usable signal. It combines four checks. Two of them arrive from outside as status levels: amplitude-OK and carrier-OK. The other two it makes itself. The first is a frequency check of the recovered character clock against the local reference clock. The second is a transition-density check on the recovered bits. The link is declared good only when all four checks pass. The verdict is published as an active-low link-fault indicator in the recovered-clock domain.

The frequency check counts recovered-clock cycles over a fixed window of reference-clock cycles. It hands the count to the reference domain with a toggle handshake and compares it with bounds. Those bounds come from the speed and range straps and a parts-per-million tolerance. A separate out-of-range flag in the reference domain tells the clock-recovery loop when to stop following the data and follow the reference clock instead.

Recovered characters arrive as a stream qualified by `rx_valid`. There is no ready signal, because a recovered stream cannot be stalled. Every character with `rx_valid` high is consumed on the rx_clk edge that samples it, and cycles with `rx_valid` low carry nothing.

Top module: `link_sigdet`

## Requirements
- R1: While `rst_n` is low, `link_fault_n` is 0 and `freq_out_of_range` is 1.
- R2: `link_fault_n` is a register clocked by `rx_clk`. It is 1 only when amplitude, carrier, frequency and transition density are all good, and it changes only on rising edges of `rx_clk`.
- R3: `amp_ok` and `carrier_ok` each pass through a two-flop synchronizer in the `rx_clk` domain. A change on either input reaches `link_fault_n` on the third rising `rx_clk` edge after it, not sooner.
- R4: The rx_clk cycles are counted over windows of `WIN_REF` ref_clk cycles and compared with E ± floor(E·PPM/10^6). E depends on the selects, given as {spd_sel,rng_sel}: 00 gives WIN_REF/2, 01 gives WIN_REF/4, 10 gives WIN_REF, and 11 gives WIN_REF/2. A count inside the bounds is a pass.
- R5: The in-range state changes only when two consecutive window results agree on the new value. `freq_out_of_range` is the inverse of that state.
- R6: If no count has returned from the rx_clk domain by the end of the next window, that window counts as a fail. A stopped `rx_clk` therefore raises `freq_out_of_range`.
- R7: Transition density fails when the current run of identical bits reaches `run_limit` bits. Bit 0 of `rx_bits` is the earliest bit, and runs continue across characters. Characters with `rx_valid` low do not change the run.
- R8: While `rx_clk` has no edges, `link_fault_n` holds its value whatever the status inputs do.
- R9: The in-range state crosses into the `rx_clk` domain through a two-flop synchronizer before it gates `link_fault_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock |
| rx_clk | input | 1 | Recovered character clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_valid | input | 1 | Character on `rx_bits` is valid this rx_clk cycle |
| rx_bits | input | CHAR_W | Recovered character, bit 0 earliest |
| amp_ok | input | 1 | Asynchronous amplitude-good status |
| carrier_ok | input | 1 | Asynchronous carrier-present status |
| spd_sel | input | 1 | Speed strap (high selects the faster bit-rate band) |
| rng_sel | input | 1 | Range strap (high selects the faster reference band) |
| run_limit | input | RUN_W | Run length, in bits, that fails the density check |
| link_fault_n | output | 1 | Active-low link fault, rx_clk domain |
| freq_out_of_range | output | 1 | Recovered rate outside bounds, ref_clk domain |

## Verification
Some rules are checked on every cycle by assertions inside the RTL. The in-range state never flips without two agreeing results. The count acknowledge toggles only in answer to a request. Ignored characters leave the run length alone, and a character ending in a bit change clears the density fault. The output stays low whenever the synchronized amplitude or density result was bad. The bench has to show the rest with timed scenarios. That covers the three-edge synchronizer latency and the ppm bounds for each strap setting, under several clock deviations. It also covers the run threshold across character boundaries, the timeout when the recovered clock stops, and the frozen output during that stop.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef enum logic [1:0] {
    CFG_SLOW_LOREF = 2'b00,
    CFG_SLOW_HIREF = 2'b01,
    CFG_FAST_LOREF = 2'b10,
    CFG_FAST_HIREF = 2'b11
  } rate_cfg_e;

  // Expected character-clock count in a window of win reference cycles.
  function automatic longint unsigned exp_count(longint unsigned win, logic [1:0] cfg);
    case (rate_cfg_e'(cfg))
      CFG_SLOW_LOREF: return win / 2;
      CFG_SLOW_HIREF: return win / 4;
      CFG_FAST_LOREF: return win;
      default:        return win / 2;
    endcase
  endfunction

  function automatic longint unsigned tol_count(longint unsigned e, longint unsigned ppm);
    return (e * ppm) / 64'd1000000;
  endfunction

endpackage

// File: rtl/lsd_sync2.sv
module lsd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lsd_density.sv
module lsd_density #(
  parameter int CHAR_W = 10,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CHAR_W-1:0] bits,
  input  logic [RUN_W-1:0]  run_limit,
  output logic              dens_ok
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q, run_w, run_d;
  logic             last_q, last_d;
  logic             prev;

  // Walk the character bit by bit, earliest bit first.
  always_comb begin
    run_w = run_q;
    prev  = last_q;
    for (int i = 0; i < CHAR_W; i++) begin
      if (bits[i] == prev) begin
        if (run_w != RUN_MAX) run_w = run_w + 1'b1;
      end else begin
        run_w = RUN_W'(1);
      end
      prev = bits[i];
    end
  end

  assign run_d  = valid ? run_w : run_q;
  assign last_d = valid ? bits[CHAR_W-1] : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      last_q  <= 1'b0;
      dens_ok <= 1'b0;
    end else begin
      run_q   <= run_d;
      last_q  <= last_d;
      dens_ok <= (run_d < run_limit);
    end
  end

  AST_IDLE_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(run_q)); // R7
  AST_EDGE_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (bits[CHAR_W-1] != bits[CHAR_W-2]) && (run_limit > RUN_W'(1))) |=> dens_ok); // R7
endmodule

// File: rtl/lsd_freq_mon.sv
module lsd_freq_mon #(
  parameter int WIN_REF = 50000,
  parameter int PPM     = 400
) (
  input  logic       ref_clk,
  input  logic       rx_clk,
  input  logic       rst_n,
  input  logic [1:0] cfg,
  output logic       in_range
);
  localparam int CNT_W = $clog2(2 * WIN_REF + 2);
  localparam int WIN_W = $clog2(WIN_REF + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int NCFG = 4;

  // Bounds per strap setting, computed at elaboration.
  logic [CNT_W-1:0] lo_tab [NCFG];
  logic [CNT_W-1:0] hi_tab [NCFG];
  for (genvar g = 0; g < NCFG; g++) begin : g_bounds
    localparam longint unsigned EXP = lsd_pkg::exp_count(longint'(WIN_REF), 2'(g));
    localparam longint unsigned TOL = lsd_pkg::tol_count(EXP, longint'(PPM));
    assign lo_tab[g] = CNT_W'(EXP - TOL);
    assign hi_tab[g] = CNT_W'(EXP + TOL);
  end

  // ---------------- rx_clk domain: counter and capture ----------------
  logic             req_tgl, req_s, req_s_d;
  logic             ack_tgl;
  logic [CNT_W-1:0] rx_cnt, hold_cnt;

  lsd_sync2 #(.W(1)) u_req_sync (.clk(rx_clk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s_d  <= 1'b0;
      rx_cnt   <= '0;
      hold_cnt <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_s_d <= req_s;
      if (req_s != req_s_d) begin
        hold_cnt <= rx_cnt;
        rx_cnt   <= CNT_W'(1);
        ack_tgl  <= ~ack_tgl;
      end else if (rx_cnt != CNT_MAX) begin
        rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end

  AST_ACK_ANSWERS_REQ: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (ack_tgl != $past(ack_tgl)) |-> $past(req_s != req_s_d)); // R4

  // ---------------- ref_clk domain: window, compare, hysteresis -------
  logic [WIN_W-1:0] win_cnt;
  logic             win_end;
  logic             ack_s, ack_s_d;
  logic             pending;
  logic             ack_new;
  logic             res_valid, res_pass, res_prev;
  logic             cnt_ok;

  lsd_sync2 #(.W(1)) u_ack_sync (.clk(ref_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));

  assign win_end   = (win_cnt == WIN_W'(WIN_REF - 1));
  assign pending   = req_tgl ^ ack_s;
  assign ack_new   = ack_s ^ ack_s_d;
  // hold_cnt has been stable for at least two ref cycles when ack_new fires.
  assign cnt_ok    = (hold_cnt >= lo_tab[cfg]) && (hold_cnt <= hi_tab[cfg]);
  assign res_valid = ack_new || (win_end && pending);
  assign res_pass  = ack_new && cnt_ok;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      req_tgl  <= 1'b0;
      ack_s_d  <= 1'b0;
      res_prev <= 1'b0;
      in_range <= 1'b0;
    end else begin
      ack_s_d <= ack_s;
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      if (win_end && !pending) req_tgl <= ~req_tgl;
      if (res_valid) begin
        res_prev <= res_pass;
        if (res_pass == res_prev) in_range <= res_pass;
      end
    end
  end

  AST_TWO_AGREE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (in_range != $past(in_range)) |->
      ($past(res_valid) && ($past(res_pass) == in_range) && ($past(res_prev) == in_range))); // R5
endmodule

// File: rtl/link_sigdet.sv
module link_sigdet #(
  parameter int WIN_REF = 50000,
  parameter int PPM     = 400,
  parameter int CHAR_W  = 10,
  parameter int RUN_W   = 8
) (
  input  logic              ref_clk,
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_bits,
  input  logic              amp_ok,
  input  logic              carrier_ok,
  input  logic              spd_sel,
  input  logic              rng_sel,
  input  logic [RUN_W-1:0]  run_limit,
  output logic              link_fault_n,
  output logic              freq_out_of_range
);
  logic [1:0] cfg_s;
  logic [1:0] stat_s;
  logic       in_range;
  logic       freq_ok_s;
  logic       dens_ok;
  logic       amp_s, car_s;

  // Straps into the reference domain.
  lsd_sync2 #(.W(2)) u_cfg_sync (
    .clk(ref_clk), .rst_n(rst_n), .d({spd_sel, rng_sel}), .q(cfg_s));

  // Asynchronous status levels into the recovered domain.
  lsd_sync2 #(.W(2)) u_stat_sync (
    .clk(rx_clk), .rst_n(rst_n), .d({amp_ok, carrier_ok}), .q(stat_s));
  assign amp_s = stat_s[1];
  assign car_s = stat_s[0];

  lsd_freq_mon #(.WIN_REF(WIN_REF), .PPM(PPM)) u_freq (
    .ref_clk(ref_clk), .rx_clk(rx_clk), .rst_n(rst_n),
    .cfg(cfg_s), .in_range(in_range));

  assign freq_out_of_range = ~in_range;

  lsd_sync2 #(.W(1)) u_freq_sync (
    .clk(rx_clk), .rst_n(rst_n), .d(in_range), .q(freq_ok_s));

  lsd_density #(.CHAR_W(CHAR_W), .RUN_W(RUN_W)) u_dens (
    .clk(rx_clk), .rst_n(rst_n), .valid(rx_valid), .bits(rx_bits),
    .run_limit(run_limit), .dens_ok(dens_ok));

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) link_fault_n <= 1'b0;
    else        link_fault_n <= amp_s & car_s & freq_ok_s & dens_ok;
  end

  AST_AMP_GATES_LINK: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !$past(amp_s) |-> !link_fault_n); // R2
  AST_CARRIER_GATES_LINK: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !$past(car_s) |-> !link_fault_n); // R3
  AST_DENS_GATES_LINK: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !$past(dens_ok) |-> !link_fault_n); // R7
  AST_FREQ_GATES_LINK: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !$past(freq_ok_s) |-> !link_fault_n); // R9
endmodule

// File: tb/link_sigdet_tb.sv
`timescale 1ns/1ps
module link_sigdet_tb;
  localparam int WIN = 1000;
  localparam int PPM = 20000;
  localparam int CW  = 10;
  localparam int RW  = 8;
  localparam real REF_P = 8.0;

  logic ref_clk = 0, rx_clk = 0, rst_n = 0;
  logic rx_valid = 0;
  logic [CW-1:0] rx_bits = '0;
  logic amp_ok = 1, carrier_ok = 1, spd_sel = 1, rng_sel = 0;
  logic [RW-1:0] run_limit = 8'd60;
  logic link_fault_n, freq_out_of_range;

  real rx_half = 4.016;
  bit  rx_run  = 1;
  int  checks = 0, failures = 0;
  int  b_run; bit b_last;

  link_sigdet #(.WIN_REF(WIN), .PPM(PPM), .CHAR_W(CW), .RUN_W(RW)) u_dut (
    .ref_clk(ref_clk), .rx_clk(rx_clk), .rst_n(rst_n), .rx_valid(rx_valid),
    .rx_bits(rx_bits), .amp_ok(amp_ok), .carrier_ok(carrier_ok),
    .spd_sel(spd_sel), .rng_sel(rng_sel), .run_limit(run_limit),
    .link_fault_n(link_fault_n), .freq_out_of_range(freq_out_of_range));

  always #(REF_P/2) ref_clk = ~ref_clk;
  always begin #(rx_half); if (rx_run) rx_clk = ~rx_clk; end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic real nominal_period(bit s, bit r);
    case ({s, r})
      2'b00: return 16.0;
      2'b01: return 32.0;
      2'b10: return 8.0;
      default: return 16.0;
    endcase
  endfunction

  // R4: expected pass for a given strap setting and rx period.
  function automatic bit expect_in(bit s, bit r, real period);
    real cnt, e, t;
    cnt = WIN * REF_P / period;
    case ({s, r})
      2'b00: e = WIN / 2;
      2'b01: e = WIN / 4;
      2'b10: e = WIN;
      default: e = WIN / 2;
    endcase
    t = $floor(e * PPM / 1.0e6);
    return (cnt >= e - t) && (cnt <= e + t);
  endfunction

  // R7: bench model of the run of identical bits.
  task automatic model_char(logic [CW-1:0] b);
    for (int i = 0; i < CW; i++) begin
      if (b[i] == b_last) begin if (b_run < 255) b_run++; end
      else b_run = 1;
      b_last = b[i];
    end
  endtask

  task automatic ref_wait(int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic rx_step(int n);
    repeat (n) @(posedge rx_clk);
    #1;
  endtask

  task automatic send_char(logic [CW-1:0] b);
    rx_bits = b; rx_valid = 1;
    rx_step(1);
    rx_valid = 0; rx_bits = '0;
    rx_step(1);
    model_char(b);
  endtask

  task automatic set_rate(bit s, bit r, real period);
    spd_sel = s; rng_sel = r; rx_half = period / 2.0;
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    failures++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C5D));
    #3;
    ref_wait(5);
    chk("R1 reset link_fault_n", link_fault_n, 0);
    chk("R1 reset freq_out_of_range", freq_out_of_range, 1);
    #2.5 rst_n = 1;
    ref_wait(20);
    chk("R1 no result before first window", freq_out_of_range, 1);

    // Nominal: fast band, low reference, +0.4% period.
    set_rate(1, 0, 8.0 * 1.004);
    ref_wait(4 * WIN + 200);
    rx_step(4);
    chk("R4 nominal in range", freq_out_of_range, 0);
    chk("R2 all checks good", link_fault_n, 1);

    // R3: amplitude latency through the synchronizer.
    amp_ok = 0;
    rx_step(2);
    chk("R3 amp drop not yet visible", link_fault_n, 1);
    rx_step(1);
    chk("R3 amp drop on third edge", link_fault_n, 0);
    amp_ok = 1;
    rx_step(3);
    chk("R2 amp restored", link_fault_n, 1);
    carrier_ok = 0;
    rx_step(2);
    chk("R3 carrier drop not yet visible", link_fault_n, 1);
    rx_step(1);
    chk("R2 carrier drop faults link", link_fault_n, 0);
    carrier_ok = 1;
    rx_step(3);

    // R7: directed run across characters, limit 60.
    b_run = 0; b_last = 0;
    send_char(10'b0101010101);
    b_run = 1; b_last = 0;
    for (int k = 0; k < 5; k++) send_char('0);
    rx_step(6);
    chk("R7 run 51 below limit, idle ignored", link_fault_n, 1);
    send_char('0);
    chk("R7 run 61 reaches limit", link_fault_n, 0);
    send_char(10'b1010101010);
    chk("R7 transition clears density fault", link_fault_n, 1);

    // R7: random characters against the bench model.
    for (int blk = 0; blk < 3; blk++) begin
      run_limit = RW'(12 + $urandom_range(0, 58));
      send_char(10'b1010101010);
      b_run = 1; b_last = 1;
      for (int k = 0; k < 20; k++) begin
        int sel;
        logic [CW-1:0] c;
        sel = $urandom_range(0, 3);
        c = (sel < 2) ? '0 : (sel == 2) ? '1 : CW'($urandom);
        send_char(c);
        chk($sformatf("R7 random run=%0d limit=%0d", b_run, run_limit),
            link_fault_n, (b_run < int'(run_limit)) ? 1 : 0);
      end
    end
    run_limit = 8'd60;
    send_char(10'b1010101010);

    // R5: a large deviation needs two agreeing windows.
    set_rate(1, 0, 8.0 * 1.05);
    ref_wait(WIN - 50);
    chk("R5 one window not enough", freq_out_of_range, 0);
    ref_wait(3 * WIN + 200);
    chk("R4 5% slow out of range", freq_out_of_range, 1);
    rx_step(4);
    chk("R9 range fault reaches link", link_fault_n, 0);

    // R4: random strap and deviation combinations.
    for (int t = 0; t < 8; t++) begin
      bit s, r;
      real dev, p;
      int di;
      s = 1'($urandom); r = 1'($urandom);
      di = $urandom_range(0, 3);
      dev = (di == 0) ? -0.03 : (di == 1) ? -0.005 : (di == 2) ? 0.005 : 0.03;
      p = nominal_period(s, r) * (1.0 + dev);
      set_rate(s, r, p);
      ref_wait(4 * WIN + 500);
      rx_step(4);
      chk($sformatf("R4 cfg=%0d%0d dev=%0f", s, r, dev),
          freq_out_of_range, expect_in(s, r, p) ? 0 : 1);
      chk("R9 link follows range", link_fault_n, expect_in(s, r, p) ? 1 : 0);
    end

    // Back to nominal, then stop the recovered clock.
    set_rate(0, 1, 32.0 * 1.004);
    ref_wait(4 * WIN + 500);
    rx_step(4);
    chk("R4 slow band high ref nominal", freq_out_of_range, 0);
    chk("R2 link good before stop", link_fault_n, 1);
    rx_run = 0;
    ref_wait(10);
    amp_ok = 0;
    ref_wait(4 * WIN);
    chk("R6 stopped clock is out of range", freq_out_of_range, 1);
    chk("R8 output frozen without rx edges", link_fault_n, 1);
    rx_run = 1;
    rx_step(4);
    chk("R8 output updates once edges return", link_fault_n, 0);
    amp_ok = 1;
    ref_wait(5 * WIN);
    rx_step(4);
    chk("R6 recovery after restart", freq_out_of_range, 0);
    chk("R2 link good after recovery", link_fault_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule